// File: doc/BRIEF.md
# Banked Masked Control Register File

This block holds the system-control registers of a small multithreaded core. Each register is reached through an 8-bit flat index built from a register number and a select (index = number × 8 + select). A register lives in one of three kinds of storage. Most registers have a single copy shared by the whole core. A small set has one copy for each thread context, picked by the thread ID that comes with the access. Another set has one copy for each virtual processor. For those, the copy is picked indirectly, through the virtual-processor field of the requesting thread's binding register.

Every stored copy has its own 32-bit write mask. A filtered write changes only the bits where the mask is 1. A direct write is meant for privileged or initialisation paths; it replaces the whole value and ignores the mask. A separate enable loads the mask itself. On reset, every value is cleared and every mask is set to all ones. A few key registers then take their own reset values and masks.

Top module: `ctl_regbank`

## Requirements
- R1: Indices outside the per-thread and per-virtual-processor sets select a single shared copy. A write made under any thread ID is seen by reads under every thread ID.
- R2: A filtered write (wr_en=1, wr_direct=0) stores (wr_data & mask) | (old & ~mask). Bits whose mask is 0 keep their old value.
- R3: A direct write (wr_en=1, wr_direct=1) stores wr_data unchanged, whatever the mask is.
- R4: With mask_we=1, the mask of the addressed copy becomes mask_wdata at the next edge. The stored value is left unchanged.
- R5: Indices 96, 17, 18, 19, 20, 21, 22, 23, 184 and 136 have one copy per thread context, selected by the access's thread ID.
- R6: Indices 9–15, 49–53 and 121 have one copy per virtual processor. The copy is selected by the low VW bits (VW = clog2(NUM_VP), at least 1) of the requesting thread's binding register at index 18. A field value ≥ NUM_VP selects processor 0. A write that changes the binding alters the mapping from the next access on.
- R7: After reset, each thread's register at index 96 reads 0x00400004 (bits 22 and 2 set), with mask 0xFF78FF17.
- R8: After reset, the masks are 0x08C00300 at index 104, 0x7FFF0007 at index 128 and 0x1FFFF800 at index 40.
- R9: After reset, index 121 reads 0x80000000 with mask 0x3FFFF000 for every virtual processor, and index 120 has mask 0.
- R10: After reset, index 8 reads 63 with mask 0. Index 64 and every thread's copy of index 136 have mask 0.
- R11: Every other copy resets to value 0 and mask 0xFFFFFFFF.
- R12: rd_data and rd_mask follow the read address combinationally. In the cycle of a write, a read returns the pre-write contents, and the new contents appear after the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_tid | input | TW | Thread ID of the read |
| rd_idx | input | 8 | Flat index of the read |
| rd_data | output | 32 | Stored value of the selected copy |
| rd_mask | output | 32 | Write mask of the selected copy |
| wr_en | input | 1 | Value write enable |
| wr_direct | input | 1 | 1: direct write, 0: filtered write |
| wr_tid | input | TW | Thread ID of the write and mask load |
| wr_idx | input | 8 | Flat index of the write and mask load |
| wr_data | input | 32 | Write value |
| mask_we | input | 1 | Mask load enable |
| mask_wdata | input | 32 | New mask value |

## Verification
Reads have no latency. Any effect of a write or mask load becomes visible one rising edge after it is driven. The bench drives inputs on the falling edge and compares both read outputs 1 ns later, while the old state still holds. This covers the same-cycle old-value rule. The reference model applies the driven operation only after the following rising edge. The embedded properties relate a write to the read of the same address one clock later.

// File: rtl/ctl_regbank.sv
module ctl_regbank #(
  parameter int NUM_TC = 4,
  parameter int NUM_VP = 2,
  localparam int TW = (NUM_TC > 1) ? $clog2(NUM_TC) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] rd_tid,
  input  logic [7:0]    rd_idx,
  output logic [31:0]   rd_data,
  output logic [31:0]   rd_mask,
  input  logic          wr_en,
  input  logic          wr_direct,
  input  logic [TW-1:0] wr_tid,
  input  logic [7:0]    wr_idx,
  input  logic [31:0]   wr_data,
  input  logic          mask_we,
  input  logic [31:0]   mask_wdata
);
  localparam int VW = (NUM_VP > 1) ? $clog2(NUM_VP) : 1;
  localparam int NT = 10;
  localparam int NV = 13;
  localparam int SL_STAT = 0, SL_BIND = 2, SL_LLA = 9, SV_EXB = 12;

  function automatic logic [4:0] tc_slot(input logic [7:0] i);
    case (i)
      8'd96:  return 5'h10;
      8'd17:  return 5'h11;
      8'd18:  return 5'h12;
      8'd19:  return 5'h13;
      8'd20:  return 5'h14;
      8'd21:  return 5'h15;
      8'd22:  return 5'h16;
      8'd23:  return 5'h17;
      8'd184: return 5'h18;
      8'd136: return 5'h19;
      default: return 5'h00;
    endcase
  endfunction

  function automatic logic [4:0] vp_slot(input logic [7:0] i);
    if (i >= 8'd9 && i <= 8'd15)  return {1'b1, 4'(i - 8'd9)};
    if (i >= 8'd49 && i <= 8'd53) return {1'b1, 4'(i - 8'd42)};
    if (i == 8'd121)              return {1'b1, 4'(SV_EXB)};
    return 5'h00;
  endfunction

  logic [31:0] sh_v [256];
  logic [31:0] sh_m [256];
  logic [31:0] tc_v [NUM_TC][NT];
  logic [31:0] tc_m [NUM_TC][NT];
  logic [31:0] vp_v [NUM_VP][NV];
  logic [31:0] vp_m [NUM_VP][NV];

  logic [4:0]    rs_t, rs_v, ws_t, ws_v;
  logic [VW-1:0] rd_raw, wr_raw, rd_vp, wr_vp;
  logic [31:0]   w_cur, w_msk, w_new;

  assign rs_t   = tc_slot(rd_idx);
  assign rs_v   = vp_slot(rd_idx);
  assign ws_t   = tc_slot(wr_idx);
  assign ws_v   = vp_slot(wr_idx);
  assign rd_raw = tc_v[rd_tid][SL_BIND][VW-1:0];
  assign wr_raw = tc_v[wr_tid][SL_BIND][VW-1:0];
  assign rd_vp  = ({1'b0, rd_raw} < (VW+1)'(NUM_VP)) ? rd_raw : '0;
  assign wr_vp  = ({1'b0, wr_raw} < (VW+1)'(NUM_VP)) ? wr_raw : '0;

  always_comb begin
    if (rs_t[4]) begin
      rd_data = tc_v[rd_tid][rs_t[3:0]];
      rd_mask = tc_m[rd_tid][rs_t[3:0]];
    end else if (rs_v[4]) begin
      rd_data = vp_v[rd_vp][rs_v[3:0]];
      rd_mask = vp_m[rd_vp][rs_v[3:0]];
    end else begin
      rd_data = sh_v[rd_idx];
      rd_mask = sh_m[rd_idx];
    end
  end

  always_comb begin
    if (ws_t[4]) begin
      w_cur = tc_v[wr_tid][ws_t[3:0]];
      w_msk = tc_m[wr_tid][ws_t[3:0]];
    end else if (ws_v[4]) begin
      w_cur = vp_v[wr_vp][ws_v[3:0]];
      w_msk = vp_m[wr_vp][ws_v[3:0]];
    end else begin
      w_cur = sh_v[wr_idx];
      w_msk = sh_m[wr_idx];
    end
  end

  assign w_new = wr_direct ? wr_data : ((wr_data & w_msk) | (w_cur & ~w_msk));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) begin
        sh_v[i] <= '0;
        sh_m[i] <= '1;
      end
      for (int t = 0; t < NUM_TC; t++)
        for (int s = 0; s < NT; s++) begin
          tc_v[t][s] <= '0;
          tc_m[t][s] <= '1;
        end
      for (int v = 0; v < NUM_VP; v++)
        for (int s = 0; s < NV; s++) begin
          vp_v[v][s] <= '0;
          vp_m[v][s] <= '1;
        end
      for (int t = 0; t < NUM_TC; t++) begin
        tc_v[t][SL_STAT] <= 32'h0040_0004;
        tc_m[t][SL_STAT] <= 32'hFF78_FF17;
        tc_m[t][SL_LLA]  <= 32'h0;
      end
      for (int v = 0; v < NUM_VP; v++) begin
        vp_v[v][SV_EXB] <= 32'h8000_0000;
        vp_m[v][SV_EXB] <= 32'h3FFF_F000;
      end
      sh_m[104] <= 32'h08C0_0300;
      sh_m[128] <= 32'h7FFF_0007;
      sh_m[40]  <= 32'h1FFF_F800;
      sh_m[120] <= 32'h0;
      sh_v[8]   <= 32'd63;
      sh_m[8]   <= 32'h0;
      sh_m[64]  <= 32'h0;
    end else begin
      if (wr_en) begin
        if (ws_t[4])      tc_v[wr_tid][ws_t[3:0]] <= w_new;
        else if (ws_v[4]) vp_v[wr_vp][ws_v[3:0]]  <= w_new;
        else              sh_v[wr_idx]            <= w_new;
      end
      if (mask_we) begin
        if (ws_t[4])      tc_m[wr_tid][ws_t[3:0]] <= mask_wdata;
        else if (ws_v[4]) vp_m[wr_vp][ws_v[3:0]]  <= mask_wdata;
        else              sh_m[wr_idx]            <= mask_wdata;
      end
    end
  end

  // R2
  filt_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_direct && rd_tid == wr_tid && rd_idx == wr_idx) |=>
    (!$stable(rd_idx) || !$stable(rd_tid) ||
     ((rd_data ^ $past(rd_data)) & ~$past(rd_mask)) == 32'h0));

  // R3
  direct_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_direct && rd_tid == wr_tid && rd_idx == wr_idx) |=>
    (!$stable(rd_idx) || !$stable(rd_tid) || rd_data == $past(wr_data)));

  // R4
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_we && rd_tid == wr_tid && rd_idx == wr_idx) |=>
    (!$stable(rd_idx) || !$stable(rd_tid) || rd_mask == $past(mask_wdata)));

  // R12
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !mask_we) |=>
    (!$stable(rd_idx) || !$stable(rd_tid) || ($stable(rd_data) && $stable(rd_mask))));
endmodule

// File: tb/ctl_regbank_tb.sv
`timescale 1ns/1ps
module ctl_regbank_tb;
  localparam int NUM_TC = 4;
  localparam int NUM_VP = 2;
  localparam int TW = (NUM_TC > 1) ? $clog2(NUM_TC) : 1;
  localparam int VW = (NUM_VP > 1) ? $clog2(NUM_VP) : 1;

  logic clk = 0;
  logic rst_n = 0;
  logic [TW-1:0] rd_tid = '0, wr_tid = '0;
  logic [7:0] rd_idx = '0, wr_idx = '0;
  logic [31:0] rd_data, rd_mask, wr_data = '0, mask_wdata = '0;
  logic wr_en = 0, wr_direct = 0, mask_we = 0;

  always #2.5 clk = ~clk;

  ctl_regbank #(.NUM_TC(NUM_TC), .NUM_VP(NUM_VP)) u_dut (
    .clk(clk), .rst_n(rst_n), .rd_tid(rd_tid), .rd_idx(rd_idx),
    .rd_data(rd_data), .rd_mask(rd_mask), .wr_en(wr_en), .wr_direct(wr_direct),
    .wr_tid(wr_tid), .wr_idx(wr_idx), .wr_data(wr_data),
    .mask_we(mask_we), .mask_wdata(mask_wdata));

  int tests = 0, fails = 0;
  bit done = 0;
  string ph = "";

  logic [31:0] sv [256], sm [256];
  logic [31:0] tv [NUM_TC][256], tm [NUM_TC][256];
  logic [31:0] vv [NUM_VP][256], vm [NUM_VP][256];
  int tc_list[$] = '{96, 17, 18, 19, 20, 21, 22, 23, 184, 136};
  int vp_list[$] = '{9, 10, 11, 12, 13, 14, 15, 49, 50, 51, 52, 53, 121};
  int extra[$]   = '{0, 8, 40, 64, 104, 120, 128, 18, 18};

  function automatic bit in_list(int q[$], int i);
    foreach (q[k]) if (q[k] == i) return 1;
    return 0;
  endfunction

  function automatic int vpe_of(int t);
    int b = int'(tv[t][18]) & ((1 << VW) - 1);
    return (b < NUM_VP) ? b : 0;
  endfunction

  function automatic void model_reset();
    for (int i = 0; i < 256; i++) begin
      sv[i] = '0; sm[i] = '1;
      for (int t = 0; t < NUM_TC; t++) begin tv[t][i] = '0; tm[t][i] = '1; end
      for (int v = 0; v < NUM_VP; v++) begin vv[v][i] = '0; vm[v][i] = '1; end
    end
    for (int t = 0; t < NUM_TC; t++) begin
      tv[t][96] = 32'h0040_0004; tm[t][96] = 32'hFF78_FF17; tm[t][136] = 0;
    end
    for (int v = 0; v < NUM_VP; v++) begin
      vv[v][121] = 32'h8000_0000; vm[v][121] = 32'h3FFF_F000;
    end
    sm[104] = 32'h08C0_0300; sm[128] = 32'h7FFF_0007; sm[40] = 32'h1FFF_F800;
    sm[120] = 0; sv[8] = 63; sm[8] = 0; sm[64] = 0;
  endfunction

  function automatic void mget(int t, int i, output logic [31:0] v, output logic [31:0] m);
    if (in_list(tc_list, i)) begin v = tv[t][i]; m = tm[t][i]; end
    else if (in_list(vp_list, i)) begin v = vv[vpe_of(t)][i]; m = vm[vpe_of(t)][i]; end
    else begin v = sv[i]; m = sm[i]; end
  endfunction

  task automatic apply();
    logic [31:0] c, m, nv;
    int t = int'(wr_tid), i = int'(wr_idx), vp;
    vp = vpe_of(t);
    mget(t, i, c, m);
    nv = wr_direct ? wr_data : ((wr_data & m) | (c & ~m));
    if (wr_en) begin
      if (in_list(tc_list, i)) tv[t][i] = nv;
      else if (in_list(vp_list, i)) vv[vp][i] = nv;
      else sv[i] = nv;
    end
    if (mask_we) begin
      if (in_list(tc_list, i)) tm[t][i] = mask_wdata;
      else if (in_list(vp_list, i)) vm[vp][i] = mask_wdata;
      else sm[i] = mask_wdata;
    end
  endtask

  task automatic check_out();
    logic [31:0] ev, em;
    string tag;
    int i = int'(rd_idx);
    mget(int'(rd_tid), i, ev, em);
    if (ph != "") tag = ph;
    else if (in_list(tc_list, i)) tag = "R5";
    else if (in_list(vp_list, i)) tag = "R6";
    else tag = "R1";
    tests++;
    if (rd_data !== ev) begin
      fails++;
      $display("FAIL %s rd_data tid=%0d idx=%0d got %h exp %h", tag, rd_tid, i, rd_data, ev);
    end
    tests++;
    if (rd_mask !== em) begin
      fails++;
      $display("FAIL %s rd_mask tid=%0d idx=%0d got %h exp %h", tag, rd_tid, i, rd_mask, em);
    end
  endtask

  // Reads are checked 1 ns after the falling edge, before the write lands (R12).
  task automatic cycle();
    #1 check_out();
    @(posedge clk);
    #0.1 apply();
    @(negedge clk);
  endtask

  task automatic op(input logic we, input logic dir, input logic mwe, input int wt,
                    input int wi, input logic [31:0] wd, input logic [31:0] md,
                    input int rt, input int ri);
    wr_en = we; wr_direct = dir; mask_we = mwe; wr_tid = TW'(wt); wr_idx = 8'(wi);
    wr_data = wd; mask_wdata = md; rd_tid = TW'(rt); rd_idx = 8'(ri);
    cycle();
  endtask

  task automatic rd(input int t, input int i);
    op(0, 0, 0, 0, 0, 0, 0, t, i);
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    ph = "R7";  for (int t = 0; t < NUM_TC; t++) rd(t, 96);
    ph = "R8";  rd(0, 104); rd(1, 128); rd(2, 40);
    ph = "R9";  rd(0, 121); rd(3, 121); rd(0, 120);
    ph = "R10"; rd(0, 8); rd(1, 64); rd(2, 136); rd(3, 136);
    ph = "R11"; rd(0, 0); rd(1, 200); rd(2, 9); rd(3, 17);
    ph = "R2";  op(1, 0, 0, 1, 96, 32'hFFFF_FFFF, 0, 1, 96); rd(1, 96); rd(0, 96);
                op(1, 0, 0, 1, 96, 32'h0, 0, 1, 96); rd(1, 96);
    ph = "R3";  op(1, 1, 0, 0, 120, 32'h1234_5678, 0, 0, 120); rd(0, 120);
                op(1, 0, 0, 0, 120, 32'hFFFF_FFFF, 0, 0, 120); rd(0, 120);
    ph = "R4";  op(0, 0, 1, 0, 104, 0, 32'h0000_FFFF, 0, 104); rd(0, 104);
                op(1, 0, 0, 0, 104, 32'hABCD_ABCD, 0, 0, 104); rd(0, 104);
    ph = "R6";  op(1, 1, 0, 2, 18, 32'h1, 0, 2, 18);
                op(1, 1, 0, 2, 121, 32'hCAFE_0000, 0, 2, 121);
                rd(0, 121); rd(2, 121); rd(1, 121);
                op(1, 0, 0, 0, 9, 32'h5A5A_5A5A, 0, 2, 9); rd(2, 9); rd(0, 9);
    ph = "R5";  op(1, 1, 0, 3, 20, 32'h77, 0, 3, 20); rd(0, 20); rd(3, 20);
    ph = "R1";  op(1, 1, 0, 3, 0, 32'h1234, 0, 0, 0); rd(1, 0); rd(2, 0);
    ph = "R12"; op(1, 1, 0, 0, 48, 32'hAAAA, 0, 0, 48); rd(0, 48);
    ph = "";
    for (int n = 0; n < 4000; n++) begin
      int wi, ri;
      wi = ($urandom % 2) ? (($urandom % 3 == 0) ? tc_list[$urandom % tc_list.size()] :
           ($urandom % 2) ? vp_list[$urandom % vp_list.size()] : extra[$urandom % extra.size()])
           : int'($urandom % 256);
      ri = ($urandom % 2) ? wi : (($urandom % 2) ? vp_list[$urandom % vp_list.size()] : int'($urandom % 256));
      op(($urandom % 3) != 0, ($urandom % 4) == 0, ($urandom % 6) == 0, int'($urandom % NUM_TC),
         wi, $urandom, $urandom, int'($urandom % NUM_TC), ri);
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule